// File: doc/BRIEF.md
# PCI Configuration Header: Identification and Command/Status Dwords

This block holds the first two dwords of a PCI target's configuration space. Dword 0 is a read-only identification word. Its upper half is a device code and its lower half is a vendor code, and both are fixed by parameters. Dword 1 combines a 16-bit Command half, which software writes, with a 16-bit Status half. Hardware sets the Status flags from single-cycle event pulses, and software clears them by writing ones.

The bus protocol engine reaches the block through a simple register port. That port carries a dword index, four byte-lane enables, write data and a write strobe. Read data is combinational from the index. The Command bits leave the block as individual control outputs. A `bus_enabled` qualifier is also exported: it drops whenever Command is all zero, and the engine then answers configuration cycles only.

Top module: `pci_cfg_hdr`

## Requirements
- R1: A read of dword 0 returns `{DEV_ID, VEN_ID}` (defaults 0x0878 and 0x109E). Writes to dword 0 have no effect.
- R2: Command sits in dword 1 bits [15:0]. Only bits 0 (I/O enable), 1 (memory enable), 2 (master enable), 6 (parity-error response), 8 (SERR enable) and 9 (fast back-to-back enable) store data. Every other Command bit reads 0. Each stored bit drives its own output.
- R3: `bus_enabled` is 1 exactly when at least one stored Command bit is 1.
- R4: The status flags at dword 1 bits 31, 30, 29, 28, 27 and 24 are write-one-to-clear. Writing 1 clears the flag on the next edge. Writing 0 leaves it unchanged.
- R5: A flag sets one cycle after its event pulse. Bit 31 sets on an address or data parity error, whatever the parity-error-response bit holds. Bit 30 sets on SERR assertion, bit 29 on a received master abort and bit 28 on a received target abort.
- R6: Bit 27 sets on a signaled target abort and also on an address parity error.
- R7: Bit 24 sets on PERR seen during a master transaction, but only while Command bit 6 is 1.
- R8: Status bits [26:25] always read 01, bit 23 reads 1 and bit 20 reads 1. All other Status bits that are not flags read 0.
- R9: If a set event and a write-one-to-clear hit the same flag in the same cycle, the flag ends at 1.
- R10: Byte enables act per lane. A dword-1 write with enables [3:2] low clears no flag. A write with enables [1:0] low leaves Command unchanged.
- R11: Synchronous active-high reset clears Command and all flags. Reads of any dword other than 0 and 1 return 0, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_addr | input | ADDR_W | Dword index of the access |
| acc_be | input | 4 | Byte-lane enables |
| acc_wdata | input | 32 | Write data |
| acc_wr | input | 1 | Write strobe |
| acc_rdata | output | 32 | Read data for `acc_addr` |
| ev_addr_perr | input | 1 | Address parity error pulse |
| ev_data_perr | input | 1 | Data parity error pulse |
| ev_serr | input | 1 | SERR asserted pulse |
| ev_mabort_rx | input | 1 | Master abort received pulse |
| ev_tabort_rx | input | 1 | Target abort received pulse |
| ev_tabort_sig | input | 1 | Target abort signaled pulse |
| ev_perr_master | input | 1 | PERR observed during a master transaction |
| cmd_io_en | output | 1 | Command bit 0 |
| cmd_mem_en | output | 1 | Command bit 1 |
| cmd_master_en | output | 1 | Command bit 2 |
| cmd_perr_resp | output | 1 | Command bit 6 |
| cmd_serr_en | output | 1 | Command bit 8 |
| cmd_fb2b_en | output | 1 | Command bit 9 |
| bus_enabled | output | 1 | Low when Command is all zero |

## Verification
The bench goes after the cases that gating and lane rules can hide.

- **Parity-report gating.** A data-parity report is pulsed while parity response is off. A design that ignores Command bit 6 would set bit 24.
- **Address parity error.** A design that wires this event to one flag only would miss either bit 31 or bit 27.
- **Lane handling.** A Command-only write carries ones in the status lanes. A design that ignores the byte enables would wipe the flags. A status clear with enables [1:0] low checks that Command is left alone.
- **Set against clear.** A set event and its clear arrive in the same cycle. A design where the clear wins would read 0.
- **Constant bits and stray offsets.** The constant status bits are read back with all flags clear, and stray offsets are read and written. A design that lets other offsets through would alias dword 1.

// File: rtl/pci_cfg_hdr.sv
module pci_cfg_hdr #(
  parameter logic [15:0] DEV_ID   = 16'h0878,
  parameter logic [15:0] VEN_ID   = 16'h109E,
  parameter int          ADDR_W   = 6,
  parameter logic [15:0] CMD_MASK = 16'h0347
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [3:0]        acc_be,
  input  logic [31:0]       acc_wdata,
  input  logic              acc_wr,
  output logic [31:0]       acc_rdata,
  input  logic              ev_addr_perr,
  input  logic              ev_data_perr,
  input  logic              ev_serr,
  input  logic              ev_mabort_rx,
  input  logic              ev_tabort_rx,
  input  logic              ev_tabort_sig,
  input  logic              ev_perr_master,
  output logic              cmd_io_en,
  output logic              cmd_mem_en,
  output logic              cmd_master_en,
  output logic              cmd_perr_resp,
  output logic              cmd_serr_en,
  output logic              cmd_fb2b_en,
  output logic              bus_enabled
);
  localparam int NFLAG = 6;
  localparam int FLAG_POS [NFLAG] = '{31, 30, 29, 28, 27, 24};
  localparam logic [15:0] STS_CONST = 16'h0290;

  logic [15:0]      cmd_q;
  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] flag_set;
  logic [NFLAG-1:0] flag_clr;
  logic [15:0]      sts;
  logic             wr_cs;

  assign wr_cs = acc_wr && (acc_addr == ADDR_W'(1));

  assign flag_set[0] = ev_addr_perr | ev_data_perr;
  assign flag_set[1] = ev_serr;
  assign flag_set[2] = ev_mabort_rx;
  assign flag_set[3] = ev_tabort_rx;
  assign flag_set[4] = ev_tabort_sig | ev_addr_perr;
  assign flag_set[5] = ev_perr_master & cmd_q[6];

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign flag_clr[i] = wr_cs && acc_be[FLAG_POS[i]/8] && acc_wdata[FLAG_POS[i]];

    always_ff @(posedge clk) begin
      if (rst)              flag_q[i] <= 1'b0;
      else if (flag_set[i]) flag_q[i] <= 1'b1;
      else if (flag_clr[i]) flag_q[i] <= 1'b0;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_cmd
    always_ff @(posedge clk) begin
      if (rst)
        cmd_q[b*8 +: 8] <= 8'h00;
      else if (wr_cs && acc_be[b])
        cmd_q[b*8 +: 8] <= acc_wdata[b*8 +: 8] & CMD_MASK[b*8 +: 8];
    end
  end

  always_comb begin
    sts = STS_CONST;
    for (int i = 0; i < NFLAG; i++) sts[FLAG_POS[i]-16] = flag_q[i];
  end

  always_comb begin
    case (acc_addr)
      ADDR_W'(0): acc_rdata = {DEV_ID, VEN_ID};
      ADDR_W'(1): acc_rdata = {sts, cmd_q};
      default:    acc_rdata = 32'h0;
    endcase
  end

  assign cmd_io_en     = cmd_q[0];
  assign cmd_mem_en    = cmd_q[1];
  assign cmd_master_en = cmd_q[2];
  assign cmd_perr_resp = cmd_q[6];
  assign cmd_serr_en   = cmd_q[8];
  assign cmd_fb2b_en   = cmd_q[9];
  assign bus_enabled   = |cmd_q;
endmodule

module pci_cfg_hdr_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [3:0]        acc_be,
  input logic              acc_wr,
  input logic [31:0]       acc_rdata,
  input logic              ev_serr,
  input logic              ev_mabort_rx,
  input logic              ev_perr_master,
  input logic              cmd_io_en,
  input logic              cmd_mem_en,
  input logic              cmd_master_en,
  input logic              cmd_perr_resp,
  input logic              bus_enabled,
  input logic [5:0]        flags
);
  a_r3_bus_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !bus_enabled |-> !(cmd_io_en || cmd_mem_en || cmd_master_en || cmd_perr_resp));

  a_r5_serr_sets: assert property (@(posedge clk) disable iff (rst)
    ev_serr |=> flags[1]);

  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
    ev_mabort_rx |=> flags[2]);

  a_r7_report_gated: assert property (@(posedge clk) disable iff (rst)
    (!flags[5] && !(ev_perr_master && cmd_perr_resp)) |=> !flags[5]);

  a_r10_lane_hold: assert property (@(posedge clk) disable iff (rst)
    (flags[0] && !(acc_wr && acc_addr == ADDR_W'(1) && acc_be[3])) |=> flags[0]);

  a_r8_const_bits: assert property (@(posedge clk) disable iff (rst)
    (acc_addr == ADDR_W'(1)) |->
      (acc_rdata[26:25] == 2'b01 && acc_rdata[23] && acc_rdata[20]
       && acc_rdata[22:21] == 2'b00 && acc_rdata[19:16] == 4'h0));
endmodule

bind pci_cfg_hdr pci_cfg_hdr_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_be(acc_be), .acc_wr(acc_wr),
  .acc_rdata(acc_rdata), .ev_serr(ev_serr), .ev_mabort_rx(ev_mabort_rx),
  .ev_perr_master(ev_perr_master), .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en),
  .cmd_master_en(cmd_master_en), .cmd_perr_resp(cmd_perr_resp),
  .bus_enabled(bus_enabled), .flags(flag_q)
);

// File: tb/pci_cfg_hdr_tb_top.sv
module pci_cfg_hdr_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0]  acc_addr = '0;
  logic [3:0]  acc_be = '0;
  logic [31:0] acc_wdata = '0;
  logic        acc_wr = 1'b0;
  logic [31:0] acc_rdata;
  logic [6:0]  ev = '0;
  logic cmd_io_en, cmd_mem_en, cmd_master_en, cmd_perr_resp, cmd_serr_en, cmd_fb2b_en, bus_enabled;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [31:0] BASE = 32'h0290_0000;

  always #2 clk = ~clk;

  pci_cfg_hdr dut_i (
    .clk(clk), .rst(rst), .acc_addr(acc_addr), .acc_be(acc_be), .acc_wdata(acc_wdata),
    .acc_wr(acc_wr), .acc_rdata(acc_rdata),
    .ev_addr_perr(ev[0]), .ev_data_perr(ev[1]), .ev_serr(ev[2]), .ev_mabort_rx(ev[3]),
    .ev_tabort_rx(ev[4]), .ev_tabort_sig(ev[5]), .ev_perr_master(ev[6]),
    .cmd_io_en(cmd_io_en), .cmd_mem_en(cmd_mem_en), .cmd_master_en(cmd_master_en),
    .cmd_perr_resp(cmd_perr_resp), .cmd_serr_en(cmd_serr_en), .cmd_fb2b_en(cmd_fb2b_en),
    .bus_enabled(bus_enabled)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    acc_addr = a;
    #1;
    d = acc_rdata;
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d, input logic [6:0] e);
    @(negedge clk);
    acc_addr = a; acc_be = be; acc_wdata = d; acc_wr = 1'b1; ev = e;
    @(negedge clk);
    acc_wr = 1'b0; acc_be = '0; ev = '0;
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk);
    ev = e;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic clear_all();
    wr(6'd1, 4'b1100, 32'hFFFF_0000, 7'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(6'd0, d); check("R1 id dword", d, 32'h0878_109E);
    rd(6'd1, d); check("R11/R8 reset cmd/status", d, BASE);
    check("R3 bus off after reset", {31'd0, bus_enabled}, 32'd0);
  endtask

  task automatic t_command();
    logic [31:0] d;
    wr(6'd1, 4'b0011, 32'h0000_FFFF, 7'd0);
    rd(6'd1, d); check("R2 masked command", d, BASE | 32'h0347);
    check("R2 outputs", {26'd0, cmd_io_en, cmd_mem_en, cmd_master_en, cmd_perr_resp, cmd_serr_en, cmd_fb2b_en}, 32'h3F);
    check("R3 bus on", {31'd0, bus_enabled}, 32'd1);
    wr(6'd1, 4'b0001, 32'h0000_0000, 7'd0);
    rd(6'd1, d); check("R10 lane 1 kept", d, BASE | 32'h0300);
    wr(6'd1, 4'b0011, 32'h0000_0000, 7'd0);
    check("R3 bus off at zero command", {31'd0, bus_enabled}, 32'd0);
    wr(6'd0, 4'b1111, 32'hFFFF_FFFF, 7'd0);
    rd(6'd0, d); check("R1 id not writable", d, 32'h0878_109E);
  endtask

  task automatic t_events();
    logic [31:0] d;
    pulse(7'b0000100); rd(6'd1, d); check("R5 serr -> bit30", d, BASE | 32'h4000_0000); clear_all();
    pulse(7'b0001000); rd(6'd1, d); check("R5 mabort -> bit29", d, BASE | 32'h2000_0000); clear_all();
    pulse(7'b0010000); rd(6'd1, d); check("R5 tabort rx -> bit28", d, BASE | 32'h1000_0000); clear_all();
    pulse(7'b0000010); rd(6'd1, d); check("R5 data perr -> bit31 without resp", d, BASE | 32'h8000_0000); clear_all();
    pulse(7'b0100000); rd(6'd1, d); check("R6 tabort sig -> bit27", d, BASE | 32'h0800_0000); clear_all();
    pulse(7'b0000001); rd(6'd1, d); check("R6 addr perr -> bits31,27", d, BASE | 32'h8800_0000); clear_all();
  endtask

  task automatic t_parity_gate();
    logic [31:0] d;
    pulse(7'b1000000); rd(6'd1, d); check("R7 no report when resp off", d, BASE);
    wr(6'd1, 4'b0001, 32'h0000_0040, 7'd0);
    pulse(7'b1000000); rd(6'd1, d); check("R7 report when resp on", d, BASE | 32'h0100_0040);
    wr(6'd1, 4'b1111, 32'h0100_0000, 7'd0);
    rd(6'd1, d); check("R4 clear bit24 and zero cmd", d, BASE);
  endtask

  task automatic t_w1c_lanes();
    logic [31:0] d;
    pulse(7'b0111101);
    rd(6'd1, d); check("R5 multiple flags", d, BASE | 32'hF800_0000);
    wr(6'd1, 4'b1100, 32'h0000_0000, 7'd0);
    rd(6'd1, d); check("R4 zero write keeps flags", d, BASE | 32'hF800_0000);
    wr(6'd1, 4'b0011, 32'hFFFF_0001, 7'd0);
    rd(6'd1, d); check("R10 cmd-only write keeps flags", d, BASE | 32'hF800_0001);
    wr(6'd1, 4'b1000, 32'h8000_0000, 7'd0);
    rd(6'd1, d); check("R4 clear bit31 only", d, BASE | 32'h7800_0001);
    wr(6'd1, 4'b0100, 32'h00FF_0000, 7'd0);
    rd(6'd1, d); check("R10 lane 3 clear not applied", d, BASE | 32'h7800_0001);
    clear_all();
    rd(6'd1, d); check("R4 clear all", d, BASE | 32'h0000_0001);
  endtask

  task automatic t_set_wins();
    logic [31:0] d;
    pulse(7'b0000100);
    wr(6'd1, 4'b1100, 32'h4000_0000, 7'b0000100);
    rd(6'd1, d); check("R9 set beats clear", d, BASE | 32'h4000_0001);
    clear_all();
  endtask

  task automatic t_other_offsets();
    logic [31:0] d;
    pulse(7'b0001000);
    wr(6'd2, 4'b1111, 32'hFFFF_0000, 7'd0);
    wr(6'd5, 4'b1111, 32'hFFFF_0000, 7'd0);
    rd(6'd1, d); check("R11 stray writes ignored", d, BASE | 32'h2000_0001);
    rd(6'd2, d); check("R11 offset 2 reads 0", d, 32'h0);
    rd(6'd63, d); check("R11 offset 63 reads 0", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_command();
    t_events();
    t_parity_gate();
    t_w1c_lanes();
    t_set_wins();
    t_other_offsets();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule